// File: doc/BRIEF.md
# Fast/Normal Interrupt Arbiter

This block gathers interrupt request lines into a pending register and routes each source either to a fast interrupt output or to a normal interrupt output. A mode register chooses the route for each source. Normal sources then pass through a mask and a fixed-priority arbiter. The winner is held as a one-hot in-service word, and an encoded index register sits beside it. The CPU reads that index to find which normal source it is serving.

Software writes the mask, the mode and the two write-one-to-clear words through a single-cycle write port. It reads every register through a combinational read port. To finish with a normal source, software first clears its pending bit and then its in-service bit. The arbiter can load a new winner only once the in-service word is empty.

Top module: `intc_arbiter`

## Requirements
- R1: A high `src_req[i]` at a rising edge sets pending bit i. If a clear of the same bit arrives in the same cycle, the set wins.
- R2: Writing `wr_data` to the pending register (address 0) clears each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A mask bit (address 1, 1 = masked) stops that source from reaching the normal path only. It has no effect on the fast output.
- R4: The fast source is the lowest-index source whose mode bit is set (address 2). `fiq_o` is high exactly while that source is pending. Higher set mode bits are ignored, and those sources stay on the normal path.
- R5: The candidates for the normal path are pending, unmasked sources other than the fast source. The lowest index wins. At most one in-service bit (address 3) is ever set.
- R6: A new winner loads into the in-service register only when that register is empty. Writing 1s to address 3 clears the matching in-service bits.
- R7: The offset register (address 4) holds the index of the in-service bit when that bit loads. It returns to 0 one cycle after the in-service word is empty and the pending bit at that offset is clear.
- R8: `irq_o` is high exactly while an in-service bit is set.
- R9: After reset the mask is all ones, and the mode, pending, in-service and offset registers are 0. Reading addresses 5 to 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Request lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | NUM_SRC | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | NUM_SRC | Combinational read data |
| irq_o | output | 1 | Normal interrupt to the CPU |
| fiq_o | output | 1 | Fast interrupt to the CPU |

## Verification
The arbiter is driven with request groups of several kinds:
- two unmasked sources, which show that the lowest index wins;
- a group with its lowest member masked, which shows that the mask moves the winner upward;
- a mix of fast and normal requests, which shows that the fast source never enters the in-service word;
- a fully masked fast request, which shows that the mask has no effect on `fiq_o`;
- several mode bits set at once, which shows that only the lowest one routes to the fast output.

Directed sequences check the clear ordering. A later, higher-priority request must not displace the held winner. The offset must stay in place while its pending bit survives, and it must fall to 0 only after that bit clears.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [2:0] {
      A_PEND   = 3'd0,
      A_MASK   = 3'd1,
      A_MODE   = 3'd2,
      A_INSERV = 3'd3,
      A_OFFSET = 3'd4
   } intc_addr_e;
endpackage

// File: rtl/intc_lowest.sv
module intc_lowest #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign onehot = vec & (~vec + N'(1));
   assign any    = |vec;
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q[g] <= 1'b0;
         else if (set_i[g]) q[g] <= 1'b1;
         else if (clr_i[g]) q[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic [2:0]         rd_addr,
   output logic [NUM_SRC-1:0] rd_data,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_param
      $error("intc_arbiter: NUM_SRC must lie in 2..64");
   end

   logic [NUM_SRC-1:0] pend_q, mask_q, mode_q, inserv_q, inserv_d;
   logic [IW-1:0]      offset_q, offset_d;
   logic [NUM_SRC-1:0] fast_sel, cand, cand_oh;
   logic [IW-1:0]      fast_idx, cand_idx;
   logic               fast_any, cand_any, load;
   logic               wr_pend, wr_mask, wr_mode, wr_isr;

   assign wr_pend = wr_en && (wr_addr == A_PEND);
   assign wr_mask = wr_en && (wr_addr == A_MASK);
   assign wr_mode = wr_en && (wr_addr == A_MODE);
   assign wr_isr  = wr_en && (wr_addr == A_INSERV);

   intc_pend_bank #(.N(NUM_SRC)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_req),
      .clr_i (wr_pend ? wr_data : '0),
      .q     (pend_q)
   );

   intc_lowest #(.N(NUM_SRC), .IW(IW)) u_fast (
      .vec    (mode_q),
      .onehot (fast_sel),
      .idx    (fast_idx),
      .any    (fast_any)
   );

   assign cand = pend_q & ~mask_q & ~fast_sel;

   intc_lowest #(.N(NUM_SRC), .IW(IW)) u_win (
      .vec    (cand),
      .onehot (cand_oh),
      .idx    (cand_idx),
      .any    (cand_any)
   );

   assign load = (inserv_q == '0) && cand_any;

   always_comb begin
      inserv_d = inserv_q & ~(wr_isr ? wr_data : '0);
      if (load) inserv_d = cand_oh;
   end

   always_comb begin
      offset_d = offset_q;
      if (load)
         offset_d = cand_idx;
      else if ((inserv_q == '0) && !pend_q[offset_q])
         offset_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '1;
         mode_q   <= '0;
         inserv_q <= '0;
         offset_q <= '0;
      end else begin
         if (wr_mask) mask_q <= wr_data;
         if (wr_mode) mode_q <= wr_data;
         inserv_q <= inserv_d;
         offset_q <= offset_d;
      end
   end

   always_comb begin
      case (rd_addr)
         A_PEND:   rd_data = pend_q;
         A_MASK:   rd_data = mask_q;
         A_MODE:   rd_data = mode_q;
         A_INSERV: rd_data = inserv_q;
         A_OFFSET: rd_data = NUM_SRC'(offset_q);
         default:  rd_data = '0;
      endcase
   end

   assign irq_o = |inserv_q;
   assign fiq_o = fast_any && |(pend_q & fast_sel);
endmodule

// File: rtl/intc_arbiter_chk.sv
module intc_arbiter_chk #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] src_req,
   input logic         wr_en,
   input logic [2:0]   wr_addr,
   input logic [N-1:0] mask_q,
   input logic [N-1:0] pend_q,
   input logic [N-1:0] inserv_q,
   input logic [IW-1:0] offset_q,
   input logic         irq_o
);
   // R1
   req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_req) |=> ((pend_q & $past(src_req)) == $past(src_req)));

   // R5
   inserv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inserv_q));

   // R6
   inserv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((inserv_q != '0) && !(wr_en && wr_addr == 3'd3)) |=> $stable(inserv_q));

   // R7
   offset_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inserv_q != '0) |-> (inserv_q[offset_q] == 1'b1));

   // R3
   load_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ((inserv_q & $past(mask_q)) == '0));

   // R5
   load_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ((inserv_q & $past(pend_q)) == inserv_q));
endmodule

bind intc_arbiter intc_arbiter_chk #(.N(NUM_SRC), .IW(IW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_req  (src_req),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .mask_q   (mask_q),
   .pend_q   (pend_q),
   .inserv_q (inserv_q),
   .offset_q (offset_q),
   .irq_o    (irq_o)
);

// File: tb/intc_arbiter_tb_top.sv
`timescale 1ns/1ps
module intc_arbiter_tb_top;
   localparam int N = 8;
   localparam int NV = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_req = '0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [N-1:0] wr_data = '0;
   logic [2:0]   rd_addr = '0;
   logic [N-1:0] rd_data;
   logic         irq_o, fiq_o;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   intc_arbiter #(.NUM_SRC(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   // columns: request, mask, mode, expected in-service, expected offset, expected fast
   localparam logic [7:0] V_SRC [NV] = '{8'h0C, 8'hF0, 8'h06, 8'h02, 8'h81, 8'h0A, 8'h00};
   localparam logic [7:0] V_MSK [NV] = '{8'h00, 8'h10, 8'h00, 8'hFF, 8'h01, 8'h00, 8'h00};
   localparam logic [7:0] V_MOD [NV] = '{8'h00, 8'h00, 8'h02, 8'h02, 8'h00, 8'h0A, 8'h00};
   localparam logic [7:0] V_ISR [NV] = '{8'h04, 8'h20, 8'h04, 8'h00, 8'h80, 8'h08, 8'h00};
   localparam logic [7:0] V_OFF [NV] = '{8'd2,  8'd5,  8'd2,  8'd0,  8'd7,  8'd3,  8'd0};
   localparam logic       V_FIQ [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulse(input logic [N-1:0] v);
      @(negedge clk);
      src_req = v;
      @(negedge clk);
      src_req = '0;
   endtask

   task automatic cleanup();
      wr(3'd1, 8'hFF);
      wr(3'd0, 8'hFF);
      wr(3'd3, 8'hFF);
      wr(3'd2, 8'h00);
      repeat (3) @(negedge clk);
   endtask

   logic [N-1:0] d;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset values
      rd(3'd1, d); chk("R9 mask", d, 8'hFF);
      rd(3'd2, d); chk("R9 mode", d, 8'h00);
      rd(3'd0, d); chk("R9 pend", d, 8'h00);
      rd(3'd3, d); chk("R9 inserv", d, 8'h00);
      rd(3'd4, d); chk("R9 offset", d, 8'h00);
      rd(3'd6, d); chk("R9 unused addr", d, 8'h00);
      chk("R8 irq reset", irq_o, 0);
      chk("R4 fiq reset", fiq_o, 0);

      // table walk: R3 R4 R5 R7 R8
      for (int k = 0; k < NV; k++) begin
         cleanup();
         wr(3'd2, V_MOD[k]);
         wr(3'd1, V_MSK[k]);
         pulse(V_SRC[k]);
         repeat (2) @(negedge clk);
         rd(3'd3, d); chk($sformatf("R5 inserv vec%0d", k), d, V_ISR[k]);
         rd(3'd4, d); chk($sformatf("R7 offset vec%0d", k), d, V_OFF[k]);
         chk($sformatf("R8 irq vec%0d", k), irq_o, |V_ISR[k]);
         chk($sformatf("R4 R3 fiq vec%0d", k), fiq_o, V_FIQ[k]);
      end

      // R1 R2: pending set by request, zero-write leaves bits alone
      cleanup();
      pulse(8'h30);
      rd(3'd0, d); chk("R1 pend set", d, 8'h30);
      wr(3'd0, 8'h00);
      rd(3'd0, d); chk("R2 zero write", d, 8'h30);
      wr(3'd0, 8'h10);
      rd(3'd0, d); chk("R2 w1c", d, 8'h20);
      // R1 set wins over simultaneous clear
      @(negedge clk);
      src_req = 8'h20; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20;
      @(negedge clk);
      src_req = '0; wr_en = 1'b0;
      rd(3'd0, d); chk("R1 set beats clear", d, 8'h20);

      // R6: held winner not displaced by higher priority
      cleanup();
      wr(3'd1, 8'h00);
      pulse(8'h04);
      repeat (2) @(negedge clk);
      pulse(8'h01);
      repeat (2) @(negedge clk);
      rd(3'd3, d); chk("R6 hold winner", d, 8'h04);
      wr(3'd0, 8'h04);
      wr(3'd3, 8'h04);
      repeat (2) @(negedge clk);
      rd(3'd3, d); chk("R6 reload after clear", d, 8'h01);
      rd(3'd4, d); chk("R7 offset reload", d, 8'h00);

      // R7: offset kept while pending survives, then clears
      cleanup();
      wr(3'd1, 8'h00);
      pulse(8'h08);
      repeat (2) @(negedge clk);
      rd(3'd4, d); chk("R7 offset loaded", d, 8'h03);
      wr(3'd1, 8'hFF);
      wr(3'd3, 8'h08);
      repeat (2) @(negedge clk);
      rd(3'd3, d); chk("R6 inserv cleared", d, 8'h00);
      chk("R8 irq low", irq_o, 0);
      rd(3'd4, d); chk("R7 offset held", d, 8'h03);
      wr(3'd0, 8'h08);
      repeat (2) @(negedge clk);
      rd(3'd4, d); chk("R7 offset auto clear", d, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule